// File: doc/BRIEF.md
# Logic Analyzer Serial Command Decoder

This block sits behind a UART receiver in a logic analyzer core. It takes the received byte stream one byte per valid cycle and splits it into host commands. An opcode byte with bit 7 clear is a complete one-byte command. An opcode byte with bit 7 set is followed by four data bytes, and those bytes fill a 32-bit payload. The payload of a recognised long command is unpacked into the configuration that the capture engine reads: per-stage trigger mask, trigger value and trigger configuration, the sample clock divider, the read and delay counts, and the flag word. Each accepted long command raises a one-cycle write strobe that carries its opcode.

Short commands raise one-cycle strobes for reset, run, identify and metadata. An identify request also starts a four-byte reply on a small valid/ready transmit port. A host that has lost track of the framing sends five zero bytes. Zero bytes fill up any long command that is still open, and at least one zero is then decoded as a reset opcode, so the parser is idle again. The payload field packing follows the byte order that host software uses on the wire.

Top module: `sump_cmd_decoder`

## Requirements
- R1: After reset every configuration output is zero, all strobes are low, and tx_valid is low.
- R2: When idle, a byte with bit 7 clear is a short command. 0x00 pulses reset_stb, 0x01 pulses run_stb, 0x02 pulses id_stb and 0x04 pulses meta_stb, each for exactly one cycle, in the second cycle after the byte is accepted. Any other short byte has no effect.
- R3: When idle, a byte with bit 7 set opens a long command that takes the next four accepted bytes. The first data byte becomes payload bits 31:24. The register update and a one-cycle wr_stb with wr_op equal to the opcode are both visible in the second cycle after the fourth data byte, and not before. Data bytes are never decoded as opcodes.
- R4: Opcode 0xC0+4s writes trigger mask s, 0xC1+4s writes trigger value s, and 0xC2+4s writes trigger configuration s, for s below NSTAGE. Mask and value store the byte-reversed payload, so the last data byte lands in bits 31:24. The configuration stores the payload unchanged. trig_start[s] is bit 3 of configuration s.
- R5: Opcode 0x80 loads divider with the low DIV_W bits of the byte-reversed payload.
- R6: Opcode 0x81 sets read_m1 = {data byte 2, data byte 1} and delay_m1 = {data byte 4, data byte 3}, where data byte 1 is the first byte after the opcode.
- R7: Opcode 0x82 sets flags = {data byte 2, data byte 1}. Data bytes 3 and 4 are ignored. The decoded outputs are demux_en = bit 0, filter_en = bit 1, group_en[g] = NOT bit 2+g, and rle_en = bit 8.
- R8: Any other opcode with bit 7 set still consumes four data bytes. It changes no register and raises no strobe, and framing continues correctly after it.
- R9: Five consecutive zero bytes, sent from any point in the framing, leave the parser idle and pulse reset_stb at least once.
- R10: After an identify request, tx_valid rises in the same cycle as id_stb. The block then presents 0x31, 0x53, 0x4C and 0x4F in that order. Each byte is held until a cycle with tx_ready high, and tx_valid drops after the fourth byte is taken.
- R11: rx_data has no effect in any cycle where rx_valid is low.
- R12: A register keeps its value through writes to any other register and through short commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_data holds a received byte this cycle |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter takes tx_data this cycle |
| tx_valid | output | 1 | Identify reply byte is pending |
| tx_data | output | 8 | Identify reply byte |
| reset_stb | output | 1 | Reset command pulse |
| run_stb | output | 1 | Run command pulse |
| id_stb | output | 1 | Identify command pulse |
| meta_stb | output | 1 | Metadata command pulse |
| wr_stb | output | 1 | Long command register write pulse |
| wr_op | output | 8 | Opcode of the last register write |
| trig_mask | output | 32*NSTAGE | Trigger masks, stage s at bits 32s+31:32s |
| trig_value | output | 32*NSTAGE | Trigger values, same packing |
| trig_cfg | output | 32*NSTAGE | Trigger configuration words, same packing |
| trig_start | output | NSTAGE | Per-stage capture start bit |
| divider | output | DIV_W | Sample clock divider |
| read_m1 | output | 16 | Read count minus one |
| delay_m1 | output | 16 | Delay count minus one |
| flags | output | 16 | Flag word |
| demux_en | output | 1 | Double-rate sampling enable |
| filter_en | output | 1 | Noise filter enable |
| rle_en | output | 1 | Run-length encoding enable |
| group_en | output | 4 | Channel group enables, active high |

## Verification
The hardest case to reach is resynchronisation: a host sends zero bytes while the parser sits at an arbitrary depth inside a long command. Those zeros complete the open command and write partial data. The bench opens a divider write, stops after each possible number of data bytes, and then sends five zeros. It then checks the divider contents the zeros left behind, counts the reset pulses, and confirms that a following run opcode is decoded as a command. Random command streams add unknown long opcodes whose data bytes look like short opcodes, so a framing slip would show up as stray strobes.

// File: rtl/sump_cmd_pkg.sv
package sump_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int DATA_BYTES = 4;
  localparam int WORD_W    = BYTE_W * DATA_BYTES;
  localparam int HALF_W    = WORD_W / 2;
  localparam int ID_LEN    = 4;

  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_ID    = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;
  localparam logic [3:0] TRIG_HI  = 4'hC;

  localparam logic [1:0] SEL_MASK  = 2'd0;
  localparam logic [1:0] SEL_VALUE = 2'd1;
  localparam logic [1:0] SEL_CFG   = 2'd2;

  localparam int START_BIT = 3;

  typedef struct packed {
    logic              is_long;
    logic [BYTE_W-1:0] op;
    logic [WORD_W-1:0] payload;
  } cmd_t;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < DATA_BYTES; i++)
      r[i*BYTE_W +: BYTE_W] = w[(DATA_BYTES-1-i)*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] half_swap(input logic [HALF_W-1:0] h);
    return {h[BYTE_W-1:0], h[HALF_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h31;
      2'd1:    return 8'h53;
      2'd2:    return 8'h4C;
      default: return 8'h4F;
    endcase
  endfunction
endpackage

// File: rtl/sump_cmd_framer.sv
module sump_cmd_framer
  import sump_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              cmd_valid,
  output cmd_t              cmd
);
  localparam int CW = $clog2(DATA_BYTES + 1);

  logic [CW-1:0]     left_q;
  logic [BYTE_W-1:0] op_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nx;

  assign shift_nx = {shift_q[WORD_W-BYTE_W-1:0], rx_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      op_q      <= '0;
      shift_q   <= '0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (rx_valid) begin
        if (left_q == '0) begin
          if (rx_data[BYTE_W-1]) begin
            op_q    <= rx_data;
            left_q  <= CW'(DATA_BYTES);
            shift_q <= '0;
          end else begin
            cmd_valid   <= 1'b1;
            cmd.is_long <= 1'b0;
            cmd.op      <= rx_data;
            cmd.payload <= '0;
          end
        end else begin
          shift_q <= shift_nx;
          left_q  <= left_q - CW'(1);
          if (left_q == CW'(1)) begin
            cmd_valid   <= 1'b1;
            cmd.is_long <= 1'b1;
            cmd.op      <= op_q;
            cmd.payload <= shift_nx;
          end
        end
      end
    end
  end

  // R3
  cmd_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(rx_valid));

  // R11
  idle_rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(left_q) && !cmd_valid));

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |=> (left_q <= CW'(DATA_BYTES)));
endmodule

// File: rtl/sump_cfg_regs.sv
module sump_cfg_regs
  import sump_cmd_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int DIV_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  cmd_t                     cmd,
  output logic                     reset_stb,
  output logic                     run_stb,
  output logic                     id_stb,
  output logic                     meta_stb,
  output logic                     wr_stb,
  output logic [BYTE_W-1:0]        wr_op,
  output logic [NSTAGE*WORD_W-1:0] trig_mask,
  output logic [NSTAGE*WORD_W-1:0] trig_value,
  output logic [NSTAGE*WORD_W-1:0] trig_cfg,
  output logic [NSTAGE-1:0]        trig_start,
  output logic [DIV_W-1:0]         divider,
  output logic [HALF_W-1:0]        read_m1,
  output logic [HALF_W-1:0]        delay_m1,
  output logic [HALF_W-1:0]        flags
);
  logic              long_go;
  logic              short_go;
  logic              is_trig;
  logic              known_long;
  logic [1:0]        stage;
  logic [1:0]        sel;
  logic [WORD_W-1:0] rev_p;

  assign long_go  = cmd_valid && cmd.is_long;
  assign short_go = cmd_valid && !cmd.is_long;
  assign stage    = cmd.op[3:2];
  assign sel      = cmd.op[1:0];
  assign rev_p    = byte_rev(cmd.payload);

  always_comb begin
    is_trig    = (cmd.op[7:4] == TRIG_HI) && (sel != 2'd3) && (int'(stage) < NSTAGE);
    known_long = is_trig || (cmd.op == OP_DIV) || (cmd.op == OP_SIZE) || (cmd.op == OP_FLAGS);
  end

  logic [WORD_W-1:0] mask_q  [NSTAGE];
  logic [WORD_W-1:0] value_q [NSTAGE];
  logic [WORD_W-1:0] cfg_q   [NSTAGE];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[s]  <= '0;
        value_q[s] <= '0;
        cfg_q[s]   <= '0;
      end else if (long_go && is_trig && (stage == 2'(s))) begin
        case (sel)
          SEL_MASK:  mask_q[s]  <= rev_p;
          SEL_VALUE: value_q[s] <= rev_p;
          SEL_CFG:   cfg_q[s]   <= cmd.payload;
          default:   ;
        endcase
      end
    end
    assign trig_mask[s*WORD_W +: WORD_W]  = mask_q[s];
    assign trig_value[s*WORD_W +: WORD_W] = value_q[s];
    assign trig_cfg[s*WORD_W +: WORD_W]   = cfg_q[s];
    assign trig_start[s]                  = cfg_q[s][START_BIT];
  end

  logic [DIV_W-1:0]  div_q;
  logic [HALF_W-1:0] read_q;
  logic [HALF_W-1:0] delay_q;
  logic [HALF_W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      read_q  <= '0;
      delay_q <= '0;
      flags_q <= '0;
    end else if (long_go) begin
      case (cmd.op)
        OP_DIV:   div_q <= rev_p[DIV_W-1:0];
        OP_SIZE: begin
          read_q  <= half_swap(cmd.payload[WORD_W-1:HALF_W]);
          delay_q <= half_swap(cmd.payload[HALF_W-1:0]);
        end
        OP_FLAGS: flags_q <= half_swap(cmd.payload[WORD_W-1:HALF_W]);
        default:  ;
      endcase
    end
  end

  assign divider  = div_q;
  assign read_m1  = read_q;
  assign delay_m1 = delay_q;
  assign flags    = flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_stb <= 1'b0;
      run_stb   <= 1'b0;
      id_stb    <= 1'b0;
      meta_stb  <= 1'b0;
      wr_stb    <= 1'b0;
      wr_op     <= '0;
    end else begin
      reset_stb <= short_go && (cmd.op == OP_RESET);
      run_stb   <= short_go && (cmd.op == OP_RUN);
      id_stb    <= short_go && (cmd.op == OP_ID);
      meta_stb  <= short_go && (cmd.op == OP_META);
      wr_stb    <= long_go && known_long;
      if (long_go && known_long)
        wr_op <= cmd.op;
    end
  end

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reset_stb, run_stb, id_stb, meta_stb, wr_stb}));

  // R3
  wr_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(cmd_valid && cmd.is_long));

  // R12
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd.is_long && cmd.op == OP_DIV) |=> $stable(div_q));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd.is_long && cmd.op == OP_FLAGS) |=> $stable(flags_q));

  // R8
  unknown_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd.is_long && !known_long) |=> !wr_stb);
endmodule

// File: rtl/sump_id_reply.sv
module sump_id_reply
  import sump_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  logic       busy_q;
  logic [1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && tx_ready) begin
      if (idx_q == 2'(ID_LEN - 1))
        busy_q <= 1'b0;
      else
        idx_q <= idx_q + 2'd1;
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = id_byte(idx_q);

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !start) |=> (tx_valid && $stable(tx_data)));

  // R10
  tx_first_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> (tx_data == 8'h31));
endmodule

// File: rtl/sump_cmd_decoder.sv
module sump_cmd_decoder
  import sump_cmd_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int DIV_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_data,
  input  logic                     tx_ready,
  output logic                     tx_valid,
  output logic [7:0]               tx_data,
  output logic                     reset_stb,
  output logic                     run_stb,
  output logic                     id_stb,
  output logic                     meta_stb,
  output logic                     wr_stb,
  output logic [7:0]               wr_op,
  output logic [NSTAGE*32-1:0]     trig_mask,
  output logic [NSTAGE*32-1:0]     trig_value,
  output logic [NSTAGE*32-1:0]     trig_cfg,
  output logic [NSTAGE-1:0]        trig_start,
  output logic [DIV_W-1:0]         divider,
  output logic [15:0]              read_m1,
  output logic [15:0]              delay_m1,
  output logic [15:0]              flags,
  output logic                     demux_en,
  output logic                     filter_en,
  output logic                     rle_en,
  output logic [3:0]               group_en
);
  localparam int DEMUX_BIT  = 0;
  localparam int FILTER_BIT = 1;
  localparam int GROUP_LSB  = 2;
  localparam int RLE_BIT    = 8;

  logic cmd_valid;
  cmd_t cmd;
  logic id_go;

  sump_cmd_framer u_framer (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .cmd_valid (cmd_valid),
    .cmd       (cmd)
  );

  sump_cfg_regs #(.NSTAGE(NSTAGE), .DIV_W(DIV_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .reset_stb  (reset_stb),
    .run_stb    (run_stb),
    .id_stb     (id_stb),
    .meta_stb   (meta_stb),
    .wr_stb     (wr_stb),
    .wr_op      (wr_op),
    .trig_mask  (trig_mask),
    .trig_value (trig_value),
    .trig_cfg   (trig_cfg),
    .trig_start (trig_start),
    .divider    (divider),
    .read_m1    (read_m1),
    .delay_m1   (delay_m1),
    .flags      (flags)
  );

  assign id_go = cmd_valid && !cmd.is_long && (cmd.op == OP_ID);

  sump_id_reply u_id (
    .clk      (clk),
    .rst      (rst),
    .start    (id_go),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  assign demux_en  = flags[DEMUX_BIT];
  assign filter_en = flags[FILTER_BIT];
  assign rle_en    = flags[RLE_BIT];
  assign group_en  = ~flags[GROUP_LSB +: 4];

  // R10
  id_pairs_tx_chk: assert property (@(posedge clk) disable iff (rst)
    id_stb |-> tx_valid);
endmodule

// File: tb/sump_cmd_decoder_test.sv
module sump_cmd_decoder_test;
  localparam int NST = 4;
  localparam int DW  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_ready = 1'b0;
  logic tx_valid;
  logic [7:0] tx_data;
  logic reset_stb, run_stb, id_stb, meta_stb, wr_stb;
  logic [7:0] wr_op;
  logic [NST*32-1:0] trig_mask, trig_value, trig_cfg;
  logic [NST-1:0] trig_start;
  logic [DW-1:0] divider;
  logic [15:0] read_m1, delay_m1, flags;
  logic demux_en, filter_en, rle_en;
  logic [3:0] group_en;

  always #2 clk = ~clk;

  sump_cmd_decoder #(.NSTAGE(NST), .DIV_W(DW)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .reset_stb(reset_stb), .run_stb(run_stb), .id_stb(id_stb), .meta_stb(meta_stb),
    .wr_stb(wr_stb), .wr_op(wr_op), .trig_mask(trig_mask), .trig_value(trig_value),
    .trig_cfg(trig_cfg), .trig_start(trig_start), .divider(divider),
    .read_m1(read_m1), .delay_m1(delay_m1), .flags(flags), .demux_en(demux_en),
    .filter_en(filter_en), .rle_en(rle_en), .group_en(group_en)
  );

  int nchk = 0;
  int nfail = 0;

  // observed strobe counts, sampled away from the active edge
  int o_reset = 0, o_run = 0, o_id = 0, o_meta = 0, o_wr = 0;
  logic [7:0] o_lastop = 8'h00;
  always @(negedge clk) begin
    if (!rst) begin
      if (reset_stb) o_reset++;
      if (run_stb)   o_run++;
      if (id_stb)    o_id++;
      if (meta_stb)  o_meta++;
      if (wr_stb) begin o_wr++; o_lastop = wr_op; end
    end
  end

  // model state
  int m_left = 0;
  logic [7:0]  m_op = 8'h00;
  logic [31:0] m_p = 32'h0;
  logic [31:0] e_mask [NST];
  logic [31:0] e_val  [NST];
  logic [31:0] e_cfg  [NST];
  logic [DW-1:0] e_div = '0;
  logic [15:0] e_read = '0, e_delay = '0, e_flags = '0;
  int e_reset = 0, e_run = 0, e_id = 0, e_meta = 0, e_wr = 0;
  logic [7:0] e_lastop = 8'h00;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [7:0] id_exp(input int i);
    case (i)
      0: return 8'h31;
      1: return 8'h53;
      2: return 8'h4C;
      default: return 8'h4F;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] op, input logic [31:0] p);
    logic [31:0] r;
    int s;
    r = bswap(p);
    s = int'(op[3:2]);
    if (op[7:4] == 4'hC && op[1:0] != 2'd3 && s < NST) begin
      if (op[1:0] == 2'd0) e_mask[s] = r;
      else if (op[1:0] == 2'd1) e_val[s] = r;
      else e_cfg[s] = p;
      e_wr++; e_lastop = op;
    end else if (op == 8'h80) begin
      e_div = r[DW-1:0]; e_wr++; e_lastop = op;
    end else if (op == 8'h81) begin
      e_read = {p[23:16], p[31:24]}; e_delay = {p[7:0], p[15:8]};
      e_wr++; e_lastop = op;
    end else if (op == 8'h82) begin
      e_flags = {p[23:16], p[31:24]}; e_wr++; e_lastop = op;
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (m_left == 0) begin
      if (b[7]) begin m_op = b; m_left = 4; m_p = 0; end
      else case (b)
        8'h00: e_reset++;
        8'h01: e_run++;
        8'h02: e_id++;
        8'h04: e_meta++;
        default: ;
      endcase
    end else begin
      m_p = {m_p[23:0], b};
      m_left--;
      if (m_left == 0) model_write(m_op, m_p);
    end
  endtask

  // drives one byte; returns at the first falling edge after it is sampled
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'($urandom);   // R11: garbage while not valid
    model_byte(b);
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] p);
    send_byte(op);
    for (int i = 3; i >= 0; i--) send_byte(p[i*8 +: 8]);
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(req, "divider", 32'(divider), 32'(e_div));
    chk(req, "read_m1", 32'(read_m1), 32'(e_read));
    chk(req, "delay_m1", 32'(delay_m1), 32'(e_delay));
    chk(req, "flags", 32'(flags), 32'(e_flags));
    for (int s = 0; s < NST; s++) begin
      chk(req, "trig_mask", trig_mask[s*32 +: 32], e_mask[s]);
      chk(req, "trig_value", trig_value[s*32 +: 32], e_val[s]);
      chk(req, "trig_cfg", trig_cfg[s*32 +: 32], e_cfg[s]);
      chk(req, "trig_start", 32'(trig_start[s]), 32'(e_cfg[s][3]));
    end
    chk(req, "reset count", o_reset, e_reset);
    chk(req, "run count", o_run, e_run);
    chk(req, "id count", o_id, e_id);
    chk(req, "meta count", o_meta, e_meta);
    chk(req, "wr count", o_wr, e_wr);
    chk(req, "wr_op", 32'(o_lastop), 32'(e_lastop));
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] p;
    logic [7:0] b;
    int r;
    void'($urandom(32'd1234));
    for (int s = 0; s < NST; s++) begin e_mask[s] = 0; e_val[s] = 0; e_cfg[s] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_all("R1");
    chk("R1", "tx_valid", 32'(tx_valid), 0);
    chk("R1", "group_en", 32'(group_en), 32'hF);

    // R3 timing of a divider write
    send_long(8'h80, 32'h12345678);
    chk("R3", "wr_stb early", 32'(wr_stb), 0);
    chk("R3", "divider early", 32'(divider), 0);
    @(negedge clk);
    chk("R3", "wr_stb", 32'(wr_stb), 1);
    chk("R3", "wr_op", 32'(wr_op), 32'h80);
    chk("R5", "divider", 32'(divider), 32'h563412);
    @(negedge clk);
    chk("R3", "wr_stb one cycle", 32'(wr_stb), 0);

    // R2 short strobe timing
    send_byte(8'h01);
    chk("R2", "run early", 32'(run_stb), 0);
    @(negedge clk);
    chk("R2", "run pulse", 32'(run_stb), 1);
    @(negedge clk);
    chk("R2", "run one cycle", 32'(run_stb), 0);
    send_byte(8'h04); send_byte(8'h03); send_byte(8'h7F); send_byte(8'h00);
    settle();
    check_all("R2");

    // R4 trigger stages
    for (int s = 0; s < NST; s++) begin
      send_long(8'hC0 + 8'(4*s), 32'hA0B0C0D0 + 32'(s));
      send_long(8'hC1 + 8'(4*s), 32'h01020304 << s);
      send_long(8'hC2 + 8'(4*s), (s == 2) ? 32'h00000008 : 32'h00000000);
    end
    settle();
    check_all("R4");
    chk("R4", "start bit stage2", 32'(trig_start), 32'h4);

    // R6 capture size, R7 flags
    send_long(8'h81, 32'h11223344);
    send_long(8'h82, 32'h0501AABB);
    settle();
    chk("R6", "read_m1", 32'(read_m1), 32'h2211);
    chk("R6", "delay_m1", 32'(delay_m1), 32'h4433);
    chk("R7", "flags", 32'(flags), 32'h0105);
    chk("R7", "demux", 32'(demux_en), 1);
    chk("R7", "filter", 32'(filter_en), 0);
    chk("R7", "group_en", 32'(group_en), 32'hE);
    chk("R7", "rle", 32'(rle_en), 1);
    check_all("R12");

    // R8 unknown long opcode with short-looking data
    send_long(8'h83, 32'h01020401);
    send_long(8'hCF, 32'h01010101);
    settle();
    check_all("R8");
    send_byte(8'h01);
    settle();
    check_all("R8");

    // R11 data toggling while not valid
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_data = (i % 2 == 0) ? 8'h01 : 8'h80;
    end
    settle();
    check_all("R11");

    // R9 resynchronisation from every depth
    for (int k = 0; k <= 4; k++) begin
      if (k > 0) send_byte(8'h80);
      for (int j = 1; j < k; j++) send_byte(8'hE0 + 8'(j));
      r = o_reset;
      for (int z = 0; z < 5; z++) send_byte(8'h00);
      settle();
      chk("R9", "reset seen", 32'(o_reset > r), 1);
      send_byte(8'h01);
      settle();
      check_all("R9");
    end

    // R10 identify reply with backpressure
    tx_ready = 1'b0;
    send_byte(8'h02);
    @(negedge clk);
    chk("R10", "id_stb", 32'(id_stb), 1);
    chk("R10", "tx_valid", 32'(tx_valid), 1);
    repeat (3) begin
      @(negedge clk);
      chk("R10", "held byte", 32'(tx_data), 32'h31);
    end
    for (int i = 0; i < 4; i++) begin
      chk("R10", "tx_valid", 32'(tx_valid), 1);
      chk("R10", "reply byte", 32'(tx_data), 32'(id_exp(i)));
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      @(negedge clk);
    end
    chk("R10", "tx_valid after", 32'(tx_valid), 0);

    // random mix
    tx_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      r = int'($urandom_range(0, 9));
      p = $urandom;
      if (r < 3) begin
        b = 8'($urandom_range(0, 7));
        send_byte(b);
      end else if (r < 6) begin
        b = 8'hC0 | 8'($urandom_range(0, 15));
        send_long(b, p);
      end else if (r < 9) begin
        b = 8'h80 + 8'($urandom_range(0, 3));
        send_long(b, p);
      end else begin
        b = 8'h80 | 8'($urandom);
        send_long(b, p);
      end
      if (n % 8 == 7) begin
        settle();
        check_all((r < 3) ? "R2" : "R12");
      end
    end
    settle();
    check_all("R3");
    summary();
  end
endmodule